// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible register bank of a colour LCD controller. It occupies a 4 KB window on a simple 32-bit bus that is word addressed. It holds four display timing words, the base addresses of the upper and lower frame panels, a control word, and an interrupt mask. It also keeps a raw interrupt status vector that event inputs set and a clear register resets. From the stored values it derives the active line width in pixels, the active frame height in lines, the pixel depth mode, the colour and byte-order selects, and an overall display enable. Downstream fetch and timing logic use these outputs directly.

A static strap input selects a board variant in which the control word and the interrupt mask trade addresses. The swap applies to both reads and writes. Eight identification bytes sit at the top of the window. Any write to a timing word or to control raises a one-cycle invalidate pulse, so a frame in progress can be restarted. An access that hits no register reads as zero, changes nothing, and raises a one-cycle error pulse. Read data and both pulses appear on the cycle after the access.

Top module: `lcd_regfile`

## Requirements
- R1: A write to word 0, 1, 2 or 3 (timing), 4 (upper base) or 5 (lower base) stores all 32 bits. A read of that word returns the stored value on `bus_rdata` one cycle after the access. `bus_rdata` holds its value until the next read. After reset every register is zero.
- R2: `line_pixels` equals ((timing word 0 AND 0xFC) + 4) * 4. `frame_lines` equals (timing word 1 AND 0x3FF) + 1.
- R3: With `variant_sel` = 0, word 6 is the interrupt mask and word 7 is control. With `variant_sel` = 1 the two addresses are exchanged for reads and for writes.
- R4: `disp_en` is 1 only when control bit 0 and control bit 11 are both 1.
- R5: `depth_mode` is control bits [3:1]. `bgr_order` is control bit 8. `be_bytes` is control bit 9. `be_pixels` is control bit 10.
- R6: Each 1 on `evt_set` sets the matching raw status bit. Word 8 reads the raw status and word 9 reads raw status AND mask. Writing word 10 clears every raw bit written as 1. When a bit is set and cleared in the same cycle, the set wins.
- R7: `irq` is 1 exactly when some raw status bit and its mask bit are both 1.
- R8: Words 11 and 12 read the upper and lower base values.
- R9: Words 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read, in order, 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. These bytes sit in bits [7:0] and the upper bits are zero.
- R10: A read of an unmapped word returns 0. This includes word 10 and words 13 to 0x3F7. A write to any word other than 0 to 7 or 10 changes nothing. Either access sets `bus_err` for exactly the following cycle.
- R11: `invalidate` is 1 for the cycle after a write to a timing word or to control, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_sel | input | 1 | Board variant strap, swaps control and mask addresses |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window; bits [11:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| evt_set | input | 4 | Interrupt event inputs, one per status bit |
| irq | output | 1 | OR of masked status |
| invalidate | output | 1 | One-cycle pulse after a timing or control write |
| disp_en | output | 1 | Display enabled (enable and power bits set) |
| depth_mode | output | 3 | Pixel depth mode |
| bgr_order | output | 1 | BGR colour order select |
| be_bytes | output | 1 | Big-endian byte order select |
| be_pixels | output | 1 | Big-endian pixel order select |
| line_pixels | output | 11 | Active pixels per line |
| frame_lines | output | 11 | Active lines per frame |

## Verification
The geometry decode is driven with timing words at both extremes and in between. One case has field bits all zero and one has them all one, which separates the +4 and +1 offsets from off-by-one errors. Other cases set only the ignored low bits or the bits above the field, which shows that the masking is correct. Control writes are tried with only the enable bit, with only the power bit, and with both, and the same writes are repeated with the strap set to prove the address swap. Status traffic covers three cases: set alone, clear alone, and a set and a clear that hit the same bit in the same cycle. Unmapped reads and writes are followed by read-backs of every register, which shows that nothing changed.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int ID_BASE = 'h3F8;

    localparam int CTL_EN   = 0;
    localparam int CTL_PWR  = 11;
    localparam int CTL_DLO  = 1;
    localparam int CTL_BGR  = 8;
    localparam int CTL_BEB  = 9;
    localparam int CTL_BEP  = 10;

    typedef enum logic [3:0] {
        RS_NONE, RS_TIM0, RS_TIM1, RS_TIM2, RS_TIM3,
        RS_UPB, RS_LPB, RS_MASK, RS_CTRL,
        RS_RAW, RS_MSKD, RS_CLR, RS_UPCUR, RS_LPCUR, RS_IDENT
    } reg_sel_e;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
    import lcd_regs_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          swap_ctl,
    output reg_sel_e      sel,
    output logic [2:0]    ident_idx
);
    localparam int WW = AW - 2;

    logic [WW-1:0] word;

    always_comb begin
        word      = addr[AW-1:2];
        ident_idx = word[2:0];
        sel       = RS_NONE;
        if (int'(word) >= ID_BASE) begin
            sel = RS_IDENT;
        end else begin
            case (int'(word))
                0:  sel = RS_TIM0;
                1:  sel = RS_TIM1;
                2:  sel = RS_TIM2;
                3:  sel = RS_TIM3;
                4:  sel = RS_UPB;
                5:  sel = RS_LPB;
                6:  sel = swap_ctl ? RS_CTRL : RS_MASK;
                7:  sel = swap_ctl ? RS_MASK : RS_CTRL;
                8:  sel = RS_RAW;
                9:  sel = RS_MSKD;
                10: sel = RS_CLR;
                11: sel = RS_UPCUR;
                12: sel = RS_LPCUR;
                default: sel = RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_geometry.sv
module lcd_geometry #(
    parameter int GW = 11
) (
    input  logic [31:0]   tim_h,
    input  logic [31:0]   tim_v,
    output logic [GW-1:0] pix_per_line,
    output logic [GW-1:0] lines_per_frame
);
    logic [GW-1:0] h_groups;

    always_comb begin
        // ((field*4) + 4) * 4 = (field + 1) * 16, field = bits [7:2]
        h_groups        = GW'(tim_h[7:2]) + GW'(1);
        pix_per_line    = h_groups << 4;
        lines_per_frame = GW'(tim_v[9:0]) + GW'(1);
    end

endmodule

// File: rtl/lcd_regfile.sv
module lcd_regfile
    import lcd_regs_pkg::*;
#(
    parameter int IRQ_W = 4,
    parameter int GEO_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                variant_sel,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    input  logic [IRQ_W-1:0]    evt_set,
    output logic                irq,
    output logic                invalidate,
    output logic                disp_en,
    output logic [2:0]          depth_mode,
    output logic                bgr_order,
    output logic                be_bytes,
    output logic                be_pixels,
    output logic [GEO_W-1:0]    line_pixels,
    output logic [GEO_W-1:0]    frame_lines
);
    localparam int PAD_W = DATA_W - IRQ_W;

    typedef struct packed {
        logic [3:0][DATA_W-1:0] tim;
        logic [DATA_W-1:0]      upb;
        logic [DATA_W-1:0]      lpb;
        logic [DATA_W-1:0]      ctrl;
        logic [IRQ_W-1:0]       mask;
        logic [IRQ_W-1:0]       raw;
        logic [DATA_W-1:0]      rdata;
        logic                   err;
        logic                   inval;
    } regs_t;

    regs_t       st_d, st_q;
    reg_sel_e    sel;
    logic [2:0]  id_idx;
    logic [DATA_W-1:0] rd_val;
    logic        rd_ok, wr_ok;
    logic [IRQ_W-1:0] clr_bits;
    logic        do_rd, do_wr;

    lcd_addr_decode #(.AW(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .swap_ctl  (variant_sel),
        .sel       (sel),
        .ident_idx (id_idx)
    );

    lcd_geometry #(.GW(GEO_W)) u_geo (
        .tim_h           (st_q.tim[0]),
        .tim_v           (st_q.tim[1]),
        .pix_per_line    (line_pixels),
        .lines_per_frame (frame_lines)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err   = 1'b0;
        st_d.inval = 1'b0;
        do_rd    = bus_sel && !bus_wr;
        do_wr    = bus_sel && bus_wr;
        rd_val   = '0;
        rd_ok    = 1'b1;
        wr_ok    = 1'b0;
        clr_bits = '0;

        case (sel)
            RS_TIM0:  begin rd_val = st_q.tim[0]; wr_ok = 1'b1; end
            RS_TIM1:  begin rd_val = st_q.tim[1]; wr_ok = 1'b1; end
            RS_TIM2:  begin rd_val = st_q.tim[2]; wr_ok = 1'b1; end
            RS_TIM3:  begin rd_val = st_q.tim[3]; wr_ok = 1'b1; end
            RS_UPB:   begin rd_val = st_q.upb;    wr_ok = 1'b1; end
            RS_LPB:   begin rd_val = st_q.lpb;    wr_ok = 1'b1; end
            RS_MASK:  begin rd_val = {{PAD_W{1'b0}}, st_q.mask}; wr_ok = 1'b1; end
            RS_CTRL:  begin rd_val = st_q.ctrl;   wr_ok = 1'b1; end
            RS_RAW:   rd_val = {{PAD_W{1'b0}}, st_q.raw};
            RS_MSKD:  rd_val = {{PAD_W{1'b0}}, st_q.raw & st_q.mask};
            RS_CLR:   begin rd_ok = 1'b0; wr_ok = 1'b1; end
            RS_UPCUR: rd_val = st_q.upb;
            RS_LPCUR: rd_val = st_q.lpb;
            RS_IDENT: rd_val = {24'h0, ident_byte(id_idx)};
            default:  rd_ok = 1'b0;
        endcase

        if (do_rd) begin
            st_d.rdata = rd_ok ? rd_val : '0;
            st_d.err   = !rd_ok;
        end

        if (do_wr) begin
            st_d.err = !wr_ok;
            case (sel)
                RS_TIM0: begin st_d.tim[0] = bus_wdata; st_d.inval = 1'b1; end
                RS_TIM1: begin st_d.tim[1] = bus_wdata; st_d.inval = 1'b1; end
                RS_TIM2: begin st_d.tim[2] = bus_wdata; st_d.inval = 1'b1; end
                RS_TIM3: begin st_d.tim[3] = bus_wdata; st_d.inval = 1'b1; end
                RS_UPB:  st_d.upb  = bus_wdata;
                RS_LPB:  st_d.lpb  = bus_wdata;
                RS_MASK: st_d.mask = bus_wdata[IRQ_W-1:0];
                RS_CTRL: begin st_d.ctrl = bus_wdata; st_d.inval = 1'b1; end
                RS_CLR:  clr_bits  = bus_wdata[IRQ_W-1:0];
                default: ;
            endcase
        end

        // clear first, then set: a same-cycle event survives the clear
        st_d.raw = (st_q.raw & ~clr_bits) | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_err    = st_q.err;
    assign invalidate = st_q.inval;
    assign irq        = |(st_q.raw & st_q.mask);
    assign disp_en    = st_q.ctrl[CTL_EN] & st_q.ctrl[CTL_PWR];
    assign depth_mode = st_q.ctrl[CTL_DLO +: 3];
    assign bgr_order  = st_q.ctrl[CTL_BGR];
    assign be_bytes   = st_q.ctrl[CTL_BEB];
    assign be_pixels  = st_q.ctrl[CTL_BEP];

    // R10: an error pulse only follows a bus access
    assert_err_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));

    // R11: invalidate only follows a write
    assert_inval_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(bus_sel && bus_wr));

    // R4: the display can only turn on through a bus write
    assert_enable_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en) |-> $past(bus_sel && bus_wr));

    // R6: a clear with no competing event leaves the written bits at zero
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && sel == RS_CLR && evt_set == '0)
        |=> ((st_q.raw & $past(bus_wdata[IRQ_W-1:0])) == '0));

    // R6: an event bit is always recorded on the next edge
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((st_q.raw & $past(evt_set)) == $past(evt_set)));

    // R7: the interrupt line can only rise after an event or a bus write
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((evt_set != '0) || (bus_sel && bus_wr)));

    // R2: width is always a non-zero multiple of 16
    assert_width_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pixels[3:0] == 4'd0) && (line_pixels != '0));

endmodule

// File: tb/lcd_regfile_bench.sv
module lcd_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_sel = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  evt_set = '0;
    logic        irq, invalidate, disp_en, bgr_order, be_bytes, be_pixels;
    logic [2:0]  depth_mode;
    logic [10:0] line_pixels, frame_lines;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lcd_regfile u_lcd_regfile (
        .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .evt_set(evt_set), .irq(irq), .invalidate(invalidate),
        .disp_en(disp_en), .depth_mode(depth_mode), .bgr_order(bgr_order),
        .be_bytes(be_bytes), .be_pixels(be_pixels),
        .line_pixels(line_pixels), .frame_lines(frame_lines)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_tim [4];
    logic [31:0] m_up, m_lp, m_ctrl, m_rdata;
    logic [3:0]  m_mask, m_raw;
    logic        m_err, m_inv;
    logic [7:0]  m_id [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always @(posedge clk) begin
        int w;
        logic [3:0] clr;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_tim[i] = '0;
            m_up = '0; m_lp = '0; m_ctrl = '0; m_rdata = '0;
            m_mask = '0; m_raw = '0; m_err = 1'b0; m_inv = 1'b0;
        end else begin
            w = int'(bus_addr >> 2);
            clr = '0;
            m_err = 1'b0;
            m_inv = 1'b0;
            if (bus_sel && !bus_wr) begin
                m_err = 1'b0;
                if (w <= 3)                         m_rdata = m_tim[w];
                else if (w == 4 || w == 11)         m_rdata = m_up;
                else if (w == 5 || w == 12)         m_rdata = m_lp;
                else if (w == 6)                    m_rdata = variant_sel ? m_ctrl : {28'h0, m_mask};
                else if (w == 7)                    m_rdata = variant_sel ? {28'h0, m_mask} : m_ctrl;
                else if (w == 8)                    m_rdata = {28'h0, m_raw};
                else if (w == 9)                    m_rdata = {28'h0, m_raw & m_mask};
                else if (w >= 'h3F8)                m_rdata = {24'h0, m_id[w - 'h3F8]};
                else begin m_rdata = '0; m_err = 1'b1; end
            end
            if (bus_sel && bus_wr) begin
                if (w <= 3) begin m_tim[w] = bus_wdata; m_inv = 1'b1; end
                else if (w == 4) m_up = bus_wdata;
                else if (w == 5) m_lp = bus_wdata;
                else if ((w == 6 && !variant_sel) || (w == 7 && variant_sel)) m_mask = bus_wdata[3:0];
                else if (w == 6 || w == 7) begin m_ctrl = bus_wdata; m_inv = 1'b1; end
                else if (w == 10) clr = bus_wdata[3:0];
                else m_err = 1'b1;
            end
            m_raw = (m_raw & ~clr) | evt_set;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 R3 R6 R8 R9 R10 read data", bus_rdata, m_rdata);
            chk("R10 bus_err", {31'h0, bus_err}, {31'h0, m_err});
            chk("R11 invalidate", {31'h0, invalidate}, {31'h0, m_inv});
            chk("R7 irq", {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
            chk("R4 disp_en", {31'h0, disp_en}, {31'h0, m_ctrl[0] & m_ctrl[11]});
            chk("R5 mode and order", {24'h0, depth_mode, bgr_order, be_bytes, be_pixels, 2'b0},
                {24'h0, m_ctrl[3:1], m_ctrl[8], m_ctrl[9], m_ctrl[10], 2'b0});
            chk("R2 line_pixels", {21'h0, line_pixels}, ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
            chk("R2 frame_lines", {21'h0, frame_lines}, (m_tim[1] & 32'h3FF) + 32'd1);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic read_all();
        for (int w = 0; w <= 12; w++) rd(12'(w * 4));
    endtask

    initial begin
        do_reset();
        read_all();                                   // reset state, R1
        // R2 geometry patterns
        wr(12'h000, 32'h0000_00FC); wr(12'h004, 32'h0000_03FF);
        wr(12'h000, 32'h0000_0003); wr(12'h004, 32'hFFFF_FC00);
        wr(12'h000, 32'hFFFF_FF4C); wr(12'h004, 32'h0000_00EF);
        // R1 storage
        wr(12'h008, 32'hA5A5_0F0F); wr(12'h00C, 32'h1234_5678);
        wr(12'h010, 32'hDEAD_BEEF); wr(12'h014, 32'h0BAD_F00D);
        read_all();                                   // R8 current-address words
        // R4 enable, R5 mode bits
        wr(12'h01C, 32'h0000_0001); wr(12'h01C, 32'h0000_0800);
        wr(12'h01C, 32'h0000_0801); wr(12'h01C, 32'h0000_070A);
        wr(12'h01C, 32'h0000_0F0F);
        // R6, R7 status
        wr(12'h018, 32'h0000_0005);
        @(negedge clk); evt_set = 4'b0010; @(negedge clk); evt_set = 4'b0000;
        rd(12'h020); rd(12'h024);
        @(negedge clk); evt_set = 4'b0100; @(negedge clk); evt_set = 4'b0000;
        rd(12'h020); rd(12'h024);
        wr(12'h028, 32'h0000_0004); rd(12'h020);
        @(negedge clk); evt_set = 4'b1001; bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 12'h028; bus_wdata = 32'hF;        // set wins over clear
        @(negedge clk); evt_set = 4'b0000; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(12'h020);
        wr(12'h028, 32'hFFFF_FFFF); rd(12'h020);
        // R10 unmapped
        rd(12'h028); rd(12'h034); rd(12'h200); rd(12'hFDC);
        wr(12'h200, 32'hFFFF_FFFF); wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h02C, 32'h1); wr(12'hFE0, 32'h77); wr(12'h034, 32'h5);
        read_all();
        // R9 identification
        for (int i = 0; i < 8; i++) rd(12'(12'hFE0 + i * 4));
        // R3 variant swap
        variant_sel = 1'b1;
        do_reset();
        wr(12'h018, 32'h0000_0801); wr(12'h01C, 32'h0000_0003);
        rd(12'h018); rd(12'h01C);
        @(negedge clk); evt_set = 4'b0001; @(negedge clk); evt_set = 4'b0000;
        rd(12'h024);
        wr(12'h01C, 32'h0); wr(12'h018, 32'h0000_0200);
        read_all();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule